// File: doc/BRIEF.md
# Logical Tick Stream Combiner

The combiner takes two tick streams, A and B, both sampled on one shared base clock, and produces a single result tick stream. A select input picks the operation. Three operations look only at the present instant: union, intersection and difference. Two operations pair ticks by rank: the k-th tick of A is matched with the k-th tick of B, and the result emits its k-th tick at either the later or the earlier of the pair. The last operation samples A activity at the pace of B. It also reports when an interval of B held more than one A tick (data lost) or no A tick at all (a value reused).

All results are registered. The outputs for the inputs present at base-clock edge n appear just after that edge. The rank difference and the per-interval A count are tracked in every mode, so switching the select input never loses history. Both are bounded: the rank difference saturates at a parameterised limit.

Top module: `tick_combiner`

## Requirements
- R1: With op_sel = 0 (union), tick_out is high in the cycle after an edge where tick_a or tick_b was high.
- R2: With op_sel = 1 (intersection), tick_out is high in the cycle after an edge where tick_a and tick_b were both high.
- R3: With op_sel = 2 (difference), tick_out is high in the cycle after an edge where tick_a was high and tick_b low.
- R4: With op_sel = 3 (latest), the k-th result tick is emitted for the later of the k-th A tick and the k-th B tick. When they coincide, exactly one tick is emitted.
- R5: With op_sel = 4 (earliest), the k-th result tick is emitted for the earlier of the k-th A tick and the k-th B tick. When they coincide, exactly one tick is emitted.
- R6: With op_sel = 5 (sample), tick_out is high only after an edge with tick_b high. It is high when at least one A tick fell in the interval from just after the previous B tick up to and including the current one.
- R7: In sample mode, lossy_out pulses for one cycle together with the B result when that interval held two or more A ticks. It stays low in all other modes.
- R8: In sample mode, dup_out pulses for one cycle with the B result when that interval held no A tick. It stays low in all other modes.
- R9: The A-minus-B rank difference is tracked in every mode and saturates at +LIMIT and -LIMIT (default 15). Ticks beyond the limit are forgotten.
- R10: An active-low reset clears all outputs, the rank difference and the interval count. The first sample interval starts at reset.
- R11: Select codes 6 and 7 produce no result tick and no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock shared by both streams |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 3 | Operation select (0 union, 1 intersection, 2 difference, 3 latest, 4 earliest, 5 sample) |
| tick_a | input | 1 | Tick of stream A at this instant |
| tick_b | input | 1 | Tick of stream B at this instant |
| tick_out | output | 1 | Registered result tick |
| lossy_out | output | 1 | Sample interval held two or more A ticks |
| dup_out | output | 1 | Sample interval held no A tick |

## Verification
The assertions assume that tick_a, tick_b and op_sel are synchronous to clk and stable around each edge. They also assume that op_sel holds a defined value outside reset. The stimulus changes all three only at the falling edge and keeps them at zero while reset is active. The rank-pairing properties are checked only for coincident ticks, so they need no long history. Saturation and the full pairing order are covered by hand-computed sequences that start from reset.

// File: rtl/tick_comb_pkg.sv
package tick_comb_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_UNION  = 3'd0,
        OP_ISECT  = 3'd1,
        OP_MINUS  = 3'd2,
        OP_LATEST = 3'd3,
        OP_EARLY  = 3'd4,
        OP_SAMPLE = 3'd5
    } tc_op_e;

    // interval count saturates at two: enough to tell none, one, many
    localparam int SMP_W = 2;

    typedef struct packed {
        logic tick;
        logic lossy;
        logic dup;
    } tc_out_t;

endpackage

// File: rtl/tc_pointwise.sv
module tc_pointwise (
    input  logic tick_a,
    input  logic tick_b,
    output logic any_tick,
    output logic both_tick,
    output logic a_only_tick
);

    always_comb begin
        any_tick    = tick_a | tick_b;
        both_tick   = tick_a & tick_b;
        a_only_tick = tick_a & ~tick_b;
    end

endmodule

// File: rtl/tc_rank_merge.sv
module tc_rank_merge #(
    parameter int LIMIT = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_a,
    input  logic tick_b,
    output logic late_hit,
    output logic early_hit
);

    localparam int DW = $clog2(LIMIT + 1) + 1;
    localparam logic signed [DW:0] HI  = (DW+1)'(LIMIT);
    localparam logic signed [DW:0] LO  = -HI;
    localparam logic signed [DW:0] ONE = (DW+1)'(1);

    typedef struct packed {
        logic [DW-1:0] diff;
    } rank_st_t;

    rank_st_t st_d, st_q;

    logic             a_ahead, b_ahead, level;
    logic signed [DW:0] wide;

    always_comb begin
        level   = (st_q.diff == '0);
        b_ahead = st_q.diff[DW-1];
        a_ahead = !b_ahead && !level;

        // later of the pair: the tick that completes a waiting partner
        late_hit  = (tick_a && tick_b) || (tick_b && a_ahead) || (tick_a && b_ahead);
        // earlier of the pair: the tick that opens a new rank
        early_hit = (tick_a && !b_ahead) || (tick_b && !a_ahead);

        wide = $signed({st_q.diff[DW-1], st_q.diff});
        if (tick_a) wide = wide + ONE;
        if (tick_b) wide = wide - ONE;

        st_d = st_q;
        if (wide > HI)      st_d.diff = HI[DW-1:0];
        else if (wide < LO) st_d.diff = LO[DW-1:0];
        else                st_d.diff = wide[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tc_sampler.sv
module tc_sampler
    import tick_comb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_a,
    input  logic tick_b,
    output logic smp_tick,
    output logic smp_lossy,
    output logic smp_dup
);

    typedef struct packed {
        logic [SMP_W-1:0] cnt;
    } smp_st_t;

    smp_st_t st_d, st_q;
    logic    seen_one, seen_many;

    always_comb begin
        // the current instant belongs to the interval a B tick closes
        seen_one  = (st_q.cnt != '0) || tick_a;
        seen_many = st_q.cnt[1] || (st_q.cnt[0] && tick_a);

        smp_tick  = tick_b && seen_one;
        smp_lossy = tick_b && seen_many;
        smp_dup   = tick_b && !seen_one;

        st_d = st_q;
        if (tick_b)
            st_d.cnt = '0;
        else if (tick_a && !st_q.cnt[1])
            st_d.cnt = st_q.cnt + SMP_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tick_combiner.sv
module tick_combiner
    import tick_comb_pkg::*;
#(
    parameter int RANK_LIMIT = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] op_sel,
    input  logic            tick_a,
    input  logic            tick_b,
    output logic            tick_out,
    output logic            lossy_out,
    output logic            dup_out
);

    logic any_t, both_t, aonly_t;
    logic late_t, early_t;
    logic smp_t, smp_l, smp_d;

    tc_out_t out_d, out_q;

    tc_pointwise u_pw (
        .tick_a      (tick_a),
        .tick_b      (tick_b),
        .any_tick    (any_t),
        .both_tick   (both_t),
        .a_only_tick (aonly_t)
    );

    tc_rank_merge #(.LIMIT(RANK_LIMIT)) u_rank (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_a    (tick_a),
        .tick_b    (tick_b),
        .late_hit  (late_t),
        .early_hit (early_t)
    );

    tc_sampler u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_a    (tick_a),
        .tick_b    (tick_b),
        .smp_tick  (smp_t),
        .smp_lossy (smp_l),
        .smp_dup   (smp_d)
    );

    always_comb begin
        out_d = '0;
        case (op_sel)
            OP_UNION:  out_d.tick = any_t;
            OP_ISECT:  out_d.tick = both_t;
            OP_MINUS:  out_d.tick = aonly_t;
            OP_LATEST: out_d.tick = late_t;
            OP_EARLY:  out_d.tick = early_t;
            OP_SAMPLE: begin
                out_d.tick  = smp_t;
                out_d.lossy = smp_l;
                out_d.dup   = smp_d;
            end
            default:   out_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign tick_out  = out_q.tick;
    assign lossy_out = out_q.lossy;
    assign dup_out   = out_q.dup;

endmodule

// File: rtl/tc_checker.sv
module tc_checker
    import tick_comb_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [OP_W-1:0] op_sel,
    input logic            tick_a,
    input logic            tick_b,
    input logic            tick_out,
    input logic            lossy_out,
    input logic            dup_out
);

    AST_UNION_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_UNION) |=> (tick_out == ($past(tick_a) || $past(tick_b)))); // R1

    AST_ISECT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_ISECT) |=> (tick_out == ($past(tick_a) && $past(tick_b)))); // R2

    AST_MINUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_MINUS) |=> (tick_out == ($past(tick_a) && !$past(tick_b)))); // R3

    AST_LATEST_COINCIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_LATEST && tick_a && tick_b) |=> tick_out); // R4

    AST_EARLY_COINCIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_EARLY && tick_a && tick_b) |=> tick_out); // R5

    AST_SAMPLE_PACE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_SAMPLE && !tick_b) |=> !tick_out); // R6

    AST_LOSSY_NEEDS_B: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_b || op_sel != OP_SAMPLE) |=> !lossy_out); // R7

    AST_DUP_NEEDS_B: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_b || op_sel != OP_SAMPLE) |=> !dup_out); // R8

    AST_DUP_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        dup_out |-> (!tick_out && !lossy_out)); // R8

    AST_IDLE_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > OP_SAMPLE) |=> (!tick_out && !lossy_out && !dup_out)); // R11

endmodule

bind tick_combiner tc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_sel    (op_sel),
    .tick_a    (tick_a),
    .tick_b    (tick_b),
    .tick_out  (tick_out),
    .lossy_out (lossy_out),
    .dup_out   (dup_out)
);

// File: tb/sim_tick_combiner.sv
module sim_tick_combiner;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_sel = 3'd0;
    logic       tick_a = 1'b0;
    logic       tick_b = 1'b0;
    logic       tick_out, lossy_out, dup_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    tick_combiner u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_sel    (op_sel),
        .tick_a    (tick_a),
        .tick_b    (tick_b),
        .tick_out  (tick_out),
        .lossy_out (lossy_out),
        .dup_out   (dup_out)
    );

    // {op[2:0], a, b, expected tick, lossy, dup}; sequence starts from reset
    localparam logic [7:0] VEC [0:30] = '{
        8'b000_10_100, 8'b000_01_100, 8'b000_00_000,
        8'b001_11_100, 8'b001_10_000,
        8'b010_10_100, 8'b010_11_000, 8'b010_01_000,
        8'b011_01_100, 8'b011_10_000, 8'b011_10_000, 8'b011_01_100,
        8'b011_01_100, 8'b011_01_000, 8'b011_11_100, 8'b011_10_100,
        8'b100_01_100, 8'b100_10_000, 8'b100_10_100, 8'b100_11_100,
        8'b100_01_000, 8'b100_11_100,
        8'b101_10_000, 8'b101_01_100, 8'b101_01_001, 8'b101_10_000,
        8'b101_10_000, 8'b101_11_110, 8'b101_11_100, 8'b101_00_000,
        8'b110_11_000
    };

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] op, input logic a, input logic b);
        @(negedge clk);
        op_sel = op;
        tick_a = a;
        tick_b = b;
        @(posedge clk);
        #1;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        op_sel = 3'd0;
        tick_a = 1'b0;
        tick_b = 1'b0;
        rst_n  = 1'b0;
        repeat (2) @(negedge clk);
        rst_n  = 1'b1;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int hits;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: outputs clear out of reset
        check("R10", "reset tick", int'(tick_out), 0);
        check("R10", "reset flags", int'({lossy_out, dup_out}), 0);

        for (int i = 0; i < 31; i++) begin
            step(VEC[i][7:5], VEC[i][4], VEC[i][3]);
            check(tag_of(VEC[i][7:5]), $sformatf("row %0d tick", i), int'(tick_out), int'(VEC[i][2]));
            check("R7", $sformatf("row %0d lossy", i), int'(lossy_out), int'(VEC[i][1]));
            check("R8", $sformatf("row %0d dup", i), int'(dup_out), int'(VEC[i][0]));
        end

        // R10: rank difference cleared by reset (else latest would tick)
        apply_reset();
        repeat (3) step(3'd3, 1'b1, 1'b0);
        apply_reset();
        step(3'd3, 1'b0, 1'b1);
        check("R10", "latest after reset", int'(tick_out), 0);

        // R10: sample interval restarts at reset
        apply_reset();
        repeat (2) step(3'd5, 1'b1, 1'b0);
        apply_reset();
        step(3'd5, 1'b0, 1'b1);
        check("R10", "sample dup after reset", int'(dup_out), 1);
        check("R10", "sample tick after reset", int'(tick_out), 0);

        // R9: A lead saturates at 15, so only 15 of 20 B ticks complete a pair
        apply_reset();
        repeat (20) step(3'd0, 1'b1, 1'b0);
        hits = 0;
        for (int i = 0; i < 20; i++) begin
            step(3'd3, 1'b0, 1'b1);
            hits += int'(tick_out);
        end
        check("R9", "latest hits after +sat", hits, 15);

        // R5 / R9: B lead saturates at -15 under earliest
        apply_reset();
        hits = 0;
        for (int i = 0; i < 20; i++) begin
            step(3'd4, 1'b0, 1'b1);
            hits += int'(tick_out);
        end
        check("R5", "earliest B leading ticks", hits, 20);
        hits = 0;
        for (int i = 0; i < 20; i++) begin
            step(3'd4, 1'b1, 1'b0);
            hits += int'(tick_out);
        end
        check("R9", "earliest A hits after -sat", hits, 5);

        // R7: many A ticks in one B interval, then one tick
        apply_reset();
        repeat (5) step(3'd5, 1'b1, 1'b0);
        step(3'd5, 1'b0, 1'b1);
        check("R7", "lossy after five", int'(lossy_out), 1);
        check("R6", "tick after five", int'(tick_out), 1);
        step(3'd5, 1'b0, 1'b0);
        check("R7", "lossy single pulse", int'(lossy_out), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule